// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits on the cartridge side of an 8-bit handheld console bus. It watches CPU writes into the read-only address space and treats them as register writes. Those registers turn the external memory window on or off, pick the ROM bank that appears in the upper ROM window, and pick what the external window at 0xA000–0xBFFF reaches. The same selector that picks one of the RAM banks can instead point that window at one of five registers in a separate real-time clock block. Writes to 0x6000–0x7FFF are passed to the clock block as a latch-control strobe.

The controller forms the full ROM byte address for every ROM access, the RAM byte address and strobes for the external RAM, and the register index and write strobe for the clock block. For reads in the external window it steers either RAM data or clock data back to the CPU. The clock arithmetic and battery backup belong to other blocks.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the upper ROM window maps bank 1, the selector holds RAM bank 0, and the external window is closed (reads in 0xA000–0xBFFF return 0xFF).
- R2: Any address in 0x0000–0x3FFF gives rom_addr_o = {bank 0, address bits 13:0}, whatever bank is selected.
- R3: A write to 0x2000–0x3FFF loads the ROM bank from data bits 6:0, and bit 7 is ignored. A value of 0 is stored as 1. Addresses 0x4000–0x7FFF then give rom_addr_o = {bank, address bits 13:0}.
- R4: Writing exactly 0x0A to 0x0000–0x1FFF opens the external window, and any other value there closes it. While it is closed, reads in 0xA000–0xBFFF return 0xFF, and ram_en_o, ram_we_o and clk_we_o stay low.
- R5: Writing 0x00–0x03 to 0x4000–0x5FFF selects a RAM bank. While the window is open, an access in 0xA000–0xBFFF raises ram_en_o with ram_addr_o = {bank, address bits 12:0}. Reads then return ram_rdata_i, and a CPU write raises ram_we_o in the same cycle.
- R6: Writing 0x08–0x0C to 0x4000–0x5FFF selects clock register (value − 8) on clk_sel_o. Window reads then return clk_rdata_i, a CPU write raises clk_we_o, and ram_en_o and ram_we_o stay low.
- R7: Any other value written to 0x4000–0x5FFF (0x04–0x07, 0x0D–0xFF) leaves the previous selection unchanged.
- R8: A write to 0x6000–0x7FFF raises latch_wr_o in that cycle, so the clock block takes cpu_wdata_i as latch control. It changes no bank, selector or enable state.
- R9: cpu_rdata_o is 0xFF for any address outside 0xA000–0xBFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data, also forwarded to RAM and clock |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_rdata_o | output | 8 | Read data for the external window |
| rom_addr_o | output | 21 | ROM byte address |
| ram_addr_o | output | 15 | External RAM byte address |
| ram_en_o | output | 1 | External RAM access enable |
| ram_we_o | output | 1 | External RAM write enable |
| ram_rdata_i | input | 8 | External RAM read data |
| clk_sel_o | output | 3 | Clock register index (0–4) |
| clk_we_o | output | 1 | Clock register write strobe |
| clk_rdata_i | input | 8 | Data from the selected clock register |
| latch_wr_o | output | 1 | Latch-control write strobe to the clock block |

## Verification
The bench writes bank 0 and a value with bit 7 set to the ROM select window. A design that kept 0 would alias bank 0 into the upper window, and one that kept bit 7 would drive an out-of-range ROM address. It writes near-miss values to the enable and selector windows (0x1A, 0x05, 0x0D, 0xFF). A loose decoder would open the window on 0x1A by matching only the low nibble, or drop into an undefined RAM or clock mode on 0x0D. In clock mode it performs window writes and reads to catch RAM still being strobed or RAM data leaking onto the read path. It also confirms that the latch sequence 0x00 then 0x01 disturbs neither bank state nor selector state.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  typedef enum logic [2:0] {
    WIN_RAMEN,
    WIN_ROMSEL,
    WIN_BANKSEL,
    WIN_LATCH,
    WIN_EXT,
    WIN_NONE
  } win_e;

  localparam logic [7:0] OPEN_BUS = 8'hFF;

  function automatic win_e decode_win(input logic [15:0] a);
    case (a[15:13])
      3'b000:  return WIN_RAMEN;
      3'b001:  return WIN_ROMSEL;
      3'b010:  return WIN_BANKSEL;
      3'b011:  return WIN_LATCH;
      3'b101:  return WIN_EXT;
      default: return WIN_NONE;
    endcase
  endfunction

endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cart_bank_pkg::*;
#(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  parameter int unsigned CLK_BASE   = 8,
  parameter int unsigned CLK_REGS   = 5,
  parameter logic [7:0]  ENABLE_KEY = 8'h0A
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  win_e                  win_i,
  input  logic                  wr_i,
  input  logic [7:0]            wdata_i,
  output logic                  en_o,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [3:0]            sel_o
);
  localparam int unsigned NUM_RAM_BANKS = 1 << RAM_BANK_W;

  logic                  en_q;
  logic [ROM_BANK_W-1:0] rom_bank_q, bank_w;
  logic [3:0]            sel_q;
  logic                  sel_ok;

  assign bank_w = wdata_i[ROM_BANK_W-1:0];
  assign sel_ok = (wdata_i < 8'(NUM_RAM_BANKS)) ||
                  ((wdata_i >= 8'(CLK_BASE)) && (wdata_i < 8'(CLK_BASE + CLK_REGS)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      rom_bank_q <= ROM_BANK_W'(1);
      sel_q      <= '0;
    end else if (wr_i) begin
      case (win_i)
        WIN_RAMEN:   en_q <= (wdata_i == ENABLE_KEY);
        WIN_ROMSEL:  rom_bank_q <= (bank_w == '0) ? ROM_BANK_W'(1) : bank_w;
        WIN_BANKSEL: if (sel_ok) sel_q <= wdata_i[3:0];
        default: ;
      endcase
    end
  end

  assign en_o       = en_q;
  assign rom_bank_o = rom_bank_q;
  assign sel_o      = sel_q;

  assert_bank_zero_remap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && win_i == WIN_ROMSEL && wdata_i[ROM_BANK_W-1:0] == '0) |=> rom_bank_q == ROM_BANK_W'(1));

  assert_key_mismatch_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && win_i == WIN_RAMEN && wdata_i != ENABLE_KEY) |=> !en_q);

  assert_bad_sel_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && win_i == WIN_BANKSEL && wdata_i >= 8'(CLK_BASE + CLK_REGS)) |=> $stable(sel_q));

  assert_latch_no_side_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && win_i == WIN_LATCH) |=> ($stable(rom_bank_q) && $stable(sel_q) && $stable(en_q)));

endmodule

// File: rtl/cbc_map.sv
module cbc_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  parameter int unsigned CLK_BASE   = 8,
  parameter int unsigned CLK_IDX_W  = 3,
  localparam int unsigned ROM_ADDR_W = ROM_BANK_W + 14,
  localparam int unsigned RAM_ADDR_W = RAM_BANK_W + 13
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [15:0]           addr_i,
  input  logic                  wr_i,
  input  win_e                  win_i,
  input  logic                  en_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [3:0]            sel_i,
  input  logic [7:0]            ram_rdata_i,
  input  logic [7:0]            clk_rdata_i,
  output logic [ROM_ADDR_W-1:0] rom_addr_o,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_en_o,
  output logic                  ram_we_o,
  output logic [CLK_IDX_W-1:0]  clk_sel_o,
  output logic                  clk_we_o,
  output logic [7:0]            rdata_o
);
  logic                  ext_hit, clk_mode;
  logic [ROM_BANK_W-1:0] eff_bank;
  logic [3:0]            clk_off;

  assign ext_hit  = en_i && (win_i == WIN_EXT);
  assign clk_mode = (sel_i >= 4'(CLK_BASE));
  assign clk_off  = sel_i - 4'(CLK_BASE);

  // lower ROM window is hard-wired to bank 0
  assign eff_bank   = (addr_i[15:14] == 2'b01) ? rom_bank_i : '0;
  assign rom_addr_o = {eff_bank, addr_i[13:0]};

  assign ram_addr_o = {sel_i[RAM_BANK_W-1:0], addr_i[12:0]};
  assign ram_en_o   = ext_hit && !clk_mode;
  assign ram_we_o   = ram_en_o && wr_i;
  assign clk_sel_o  = clk_mode ? clk_off[CLK_IDX_W-1:0] : '0;
  assign clk_we_o   = ext_hit && clk_mode && wr_i;

  always_comb begin
    if (!ext_hit)      rdata_o = OPEN_BUS;
    else if (clk_mode) rdata_o = clk_rdata_i;
    else               rdata_o = ram_rdata_i;
  end

  assert_rom_low_bank0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (rom_addr_o[ROM_ADDR_W-1:14] == '0));

  assert_closed_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_i == WIN_EXT && !en_i) |-> (rdata_o == OPEN_BUS && !ram_we_o && !clk_we_o && !ram_en_o));

  assert_clock_mode_no_ram_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && win_i == WIN_EXT && sel_i >= 4'(CLK_BASE)) |-> (!ram_en_o && rdata_o == clk_rdata_i));

  assert_outside_open_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:13] != 3'b101) |-> (rdata_o == OPEN_BUS && !ram_en_o && !clk_we_o));

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int unsigned ROM_BANK_W = 7,
  parameter int unsigned RAM_BANK_W = 2,
  parameter int unsigned CLK_BASE   = 8,
  parameter int unsigned CLK_REGS   = 5,
  parameter logic [7:0]  ENABLE_KEY = 8'h0A,
  localparam int unsigned ROM_ADDR_W = ROM_BANK_W + 14,
  localparam int unsigned RAM_ADDR_W = RAM_BANK_W + 13,
  localparam int unsigned CLK_IDX_W  = $clog2(CLK_REGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [15:0]           cpu_addr_i,
  input  logic [7:0]            cpu_wdata_i,
  input  logic                  cpu_wr_i,
  output logic [7:0]            cpu_rdata_o,
  output logic [ROM_ADDR_W-1:0] rom_addr_o,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_en_o,
  output logic                  ram_we_o,
  input  logic [7:0]            ram_rdata_i,
  output logic [CLK_IDX_W-1:0]  clk_sel_o,
  output logic                  clk_we_o,
  input  logic [7:0]            clk_rdata_i,
  output logic                  latch_wr_o
);
  win_e                  win;
  logic                  en;
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [3:0]            sel;

  assign win        = decode_win(cpu_addr_i);
  assign latch_wr_o = cpu_wr_i && (win == WIN_LATCH);

  cbc_regs #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .CLK_BASE(CLK_BASE), .CLK_REGS(CLK_REGS), .ENABLE_KEY(ENABLE_KEY)
  ) u_regs (
    .clk_i, .rst_ni,
    .win_i(win), .wr_i(cpu_wr_i), .wdata_i(cpu_wdata_i),
    .en_o(en), .rom_bank_o(rom_bank), .sel_o(sel)
  );

  cbc_map #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .CLK_BASE(CLK_BASE), .CLK_IDX_W(CLK_IDX_W)
  ) u_map (
    .clk_i, .rst_ni,
    .addr_i(cpu_addr_i), .wr_i(cpu_wr_i), .win_i(win), .en_i(en),
    .rom_bank_i(rom_bank), .sel_i(sel),
    .ram_rdata_i, .clk_rdata_i,
    .rom_addr_o, .ram_addr_o, .ram_en_o, .ram_we_o,
    .clk_sel_o, .clk_we_o, .rdata_o(cpu_rdata_o)
  );

  assert_latch_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_wr_o |-> (!ram_we_o && !clk_we_o));

endmodule

// File: tb/tb_cart_bank_ctrl.sv
`timescale 1ns/1ps
module tb_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic [7:0]  rdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_en, ram_we, clk_we, latch_wr;
  logic [2:0]  clk_sel;
  logic [7:0]  ram_rdata = 8'h5A;
  logic [7:0]  clk_rdata = 8'h3C;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cart_bank_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata), .cpu_wr_i(wr),
    .cpu_rdata_o(rdata), .rom_addr_o(rom_addr),
    .ram_addr_o(ram_addr), .ram_en_o(ram_en), .ram_we_o(ram_we),
    .ram_rdata_i(ram_rdata), .clk_sel_o(clk_sel), .clk_we_o(clk_we),
    .clk_rdata_i(clk_rdata), .latch_wr_o(latch_wr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present a read address, sample mid-cycle
  task automatic probe(input logic [15:0] a);
    @(negedge clk);
    addr = a; wr = 1'b0;
    #1;
  endtask

  // start a write; strobes can be sampled right after return, register updates on next posedge
  task automatic wr_begin(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    #1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    wr_begin(a, d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic t_reset();
    probe(16'h4123);
    chk("R1 rom bank 1", 32'(rom_addr), 32'h4123);
    probe(16'hA000);
    chk("R1 window closed rdata", 32'(rdata), 32'hFF);
    chk("R1 window closed ram_en", 32'(ram_en), 0);
    do_write(16'h0000, 8'h0A);
    probe(16'hA010);
    chk("R1 ram bank 0 addr", 32'(ram_addr), 32'h0010);
    do_write(16'h0000, 8'h00);
  endtask

  task automatic t_rom_bank();
    do_write(16'h2000, 8'h85);
    probe(16'h7FFF);
    chk("R3 bank 5 bit7 dropped", 32'(rom_addr), {11'd0, 7'd5, 14'h3FFF});
    do_write(16'h3FFF, 8'h00);
    probe(16'h4000);
    chk("R3 zero maps to 1", 32'(rom_addr), {11'd0, 7'd1, 14'h0000});
    do_write(16'h2100, 8'h7F);
    probe(16'h5555);
    chk("R3 bank 127", 32'(rom_addr), {11'd0, 7'd127, 14'h1555});
  endtask

  task automatic t_rom_low();
    probe(16'h3ABC);
    chk("R2 low window bank 0", 32'(rom_addr), 32'h3ABC);
    probe(16'h0001);
    chk("R2 low window bank 0 start", 32'(rom_addr), 32'h0001);
  endtask

  task automatic t_enable();
    do_write(16'h0000, 8'h0A);
    probe(16'hA000);
    chk("R4 open reads ram", 32'(rdata), 32'h5A);
    do_write(16'h1000, 8'h1A);
    probe(16'hA000);
    chk("R4 0x1A closes", 32'(rdata), 32'hFF);
    wr_begin(16'hA010, 8'h11);
    chk("R4 closed no ram_we", 32'(ram_we), 0);
    chk("R4 closed no ram_en", 32'(ram_en), 0);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic t_ram_bank();
    do_write(16'h1FFF, 8'h0A);
    do_write(16'h4000, 8'h02);
    wr_begin(16'hB001, 8'h77);
    chk("R5 ram_we on write", 32'(ram_we), 1);
    chk("R5 ram_addr bank2", 32'(ram_addr), {17'd0, 2'd2, 13'h1001});
    @(negedge clk); wr = 1'b0;
    probe(16'hA123);
    chk("R5 ram_en on read", 32'(ram_en), 1);
    chk("R5 read ram data", 32'(rdata), 32'h5A);
  endtask

  task automatic t_clock();
    do_write(16'h5000, 8'h0C);
    probe(16'hA000);
    chk("R6 clk_sel 4", 32'(clk_sel), 4);
    chk("R6 read clock data", 32'(rdata), 32'h3C);
    chk("R6 ram_en low", 32'(ram_en), 0);
    wr_begin(16'hBFFF, 8'h12);
    chk("R6 clk_we", 32'(clk_we), 1);
    chk("R6 no ram_we", 32'(ram_we), 0);
    @(negedge clk); wr = 1'b0;
    do_write(16'h4000, 8'h08);
    probe(16'hA000);
    chk("R6 clk_sel 0", 32'(clk_sel), 0);
    chk("R6 clock data at 0x08", 32'(rdata), 32'h3C);
  endtask

  task automatic t_bad_sel();
    do_write(16'h4000, 8'h0A);
    do_write(16'h4000, 8'h05);
    do_write(16'h4000, 8'h0D);
    do_write(16'h4000, 8'hFF);
    probe(16'hA000);
    chk("R7 sel kept", 32'(clk_sel), 2);
    chk("R7 still clock mode", 32'(rdata), 32'h3C);
    do_write(16'h4000, 8'h03);
    do_write(16'h4000, 8'h04);
    probe(16'hA001);
    chk("R7 ram bank 3 kept", 32'(ram_addr), {17'd0, 2'd3, 13'h0001});
    chk("R7 ram mode kept", 32'(rdata), 32'h5A);
  endtask

  task automatic t_latch();
    wr_begin(16'h6000, 8'h00);
    chk("R8 latch strobe 0x00", 32'(latch_wr), 1);
    @(negedge clk); wr = 1'b0;
    wr_begin(16'h7FFF, 8'h01);
    chk("R8 latch strobe 0x01", 32'(latch_wr), 1);
    @(negedge clk); wr = 1'b0;
    probe(16'h4000);
    chk("R8 no latch when idle", 32'(latch_wr), 0);
    chk("R8 rom bank unchanged", 32'(rom_addr), {11'd0, 7'd127, 14'h0});
    probe(16'hA002);
    chk("R8 selector unchanged", 32'(ram_addr), {17'd0, 2'd3, 13'h0002});
    chk("R8 enable unchanged", 32'(rdata), 32'h5A);
  endtask

  task automatic t_outside();
    probe(16'h8000);
    chk("R9 0x8000 open bus", 32'(rdata), 32'hFF);
    probe(16'hC000);
    chk("R9 0xC000 open bus", 32'(rdata), 32'hFF);
    probe(16'h4000);
    chk("R9 rom window open bus", 32'(rdata), 32'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rom_bank();
    t_rom_low();
    t_enable();
    t_ram_bank();
    t_clock();
    t_bad_sel();
    t_latch();
    t_outside();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule